// File: doc/BRIEF.md
# Conditional Call/Return Control Unit

This unit carries out the two control-flow operations of a small virtual machine: a conditional subroutine call and a conditional return. Each accepted instruction does three things. It decides whether the branch is taken. It works out the program counter of the next instruction. It produces the C result together with a write strobe. Instruction fetch and memory access belong to neighbouring blocks.

A taken call saves a pair of values on an internal hardware stack: the A operand and the address of the instruction that follows the call. It then jumps forward by a distance taken from the low seven bits of the immediate. A taken return removes the most recent pair, produces A XOR the saved value and jumps back to the saved address. When the branch is not taken, either operation reduces to the plain copy C = A and execution moves on to the next instruction.

The unit accepts one instruction per clock on a valid strobe. Its results are registered and appear one cycle later.

Top module: `ccr_unit`

## Requirements
- R1: After a synchronous active-low reset, the stack is empty, `stack_empty` is 1, `stack_full` is 0, `overflow` is 0 and `out_valid` is 0.
- R2: The branch condition is true when `uncond` is 1. It is also true when `op_b`, compared as an unsigned 64-bit value, is less than or equal to `imm1` zero-extended to 64 bits.
- R3: An instruction whose branch is not taken gives `out_taken`=0, `out_c`=`op_a`, `out_c_wr`=1 and `out_next_pc`=`pc`+16.
- R4: A taken call (`in_op`=0) gives `out_next_pc` = `pc` + 16*(`call_ofs`+1) and `out_c_wr`=0. It pushes the pair (`op_a`, `pc`+16) onto the stack.
- R5: A return (`in_op`=1) issued while the stack is empty is never taken, even when `uncond` is 1.
- R6: A taken return pops the newest pair (value, address) and gives `out_next_pc` = address, `out_c` = `op_a` XOR value and `out_c_wr`=1.
- R7: The stack is last-in first-out: nested calls are matched by returns in reverse order.
- R8: The stack holds 16 pairs. A call whose condition is true while the stack is full is not taken, leaves the stack unchanged and sets `overflow`.
- R9: While `in_valid` is 0, the stack does not change and `out_valid` is 0 in the following cycle.
- R10: Once set, `overflow` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_op | input | 1 | 0 = call, 1 = return |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B, compared with imm1 |
| call_ofs | input | 7 | Low seven bits of the 8-bit immediate; sets the call distance |
| imm1 | input | 32 | 32-bit immediate, the comparison bound |
| uncond | input | 1 | Forces the branch condition true |
| pc | input | 32 | Byte address of the current instruction |
| out_valid | output | 1 | Registered results below are valid |
| out_taken | output | 1 | The branch was taken |
| out_next_pc | output | 32 | Address of the next instruction |
| out_c | output | 64 | C result |
| out_c_wr | output | 1 | C must be written |
| stack_empty | output | 1 | Stack holds no pairs |
| stack_full | output | 1 | Stack holds 16 pairs |
| overflow | output | 1 | Sticky: a call was refused because the stack was full |

## Verification
The assertions check these rules on every cycle:
- the stack depth stays within its bound and moves by exactly one on each push or pop;
- a return on an empty stack and a call on a full stack are always refused;
- an idle cycle produces no result;
- a not-taken result always requests a write;
- the overflow flag never clears.

Only the bench scenarios can show that the data is right: the comparison boundaries (equal, one above, values with the top bit set), the computed jump targets at the smallest and largest offsets, and the saved value and address coming back in reverse order through nested returns and after a full stack is drained.

// File: rtl/ccr_pkg.sv
// Shared constants and types for the call/return control unit.
package ccr_pkg;
    // Operation codes on in_op.
    typedef enum logic {
        OP_CALL = 1'b0,
        OP_RET  = 1'b1
    } ccr_op_e;

    // Size of one instruction in bytes.
    localparam int unsigned INSTR_BYTES = 16;
    // log2 of INSTR_BYTES, used to scale the call distance.
    localparam int unsigned INSTR_SHIFT = 4;
endpackage

// File: rtl/ccr_cond.sv
// Branch condition evaluator.
// Asserts cond when the unconditional flag is set, or when operand B,
// taken as unsigned, does not exceed the immediate bound zero-extended
// to the data width. Purely combinational.
// Assumes IW <= DW.
module ccr_cond #(
    parameter int unsigned DW = 64,
    parameter int unsigned IW = 32
) (
    input  logic [DW-1:0] b,
    input  logic [IW-1:0] bound,
    input  logic          uncond,
    output logic          cond
);
    localparam int unsigned PADW = DW - IW;

    logic [DW-1:0] bound_ext;

    // Zero-extend the bound and compare unsigned.
    always_comb begin
        bound_ext = {{PADW{1'b0}}, bound};
        cond      = uncond | (b <= bound_ext);
    end
endmodule

// File: rtl/ccr_target.sv
// Next-address calculator.
// Produces the sequential address, the forward call target and the
// return address to be saved by a call. Purely combinational.
// Assumes byte addressing and a fixed instruction size.
module ccr_target #(
    parameter int unsigned AW = 32,
    parameter int unsigned OW = 7
) (
    input  logic [AW-1:0] pc,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] seq_pc,
    output logic [AW-1:0] call_pc
);
    import ccr_pkg::*;

    logic [AW-1:0] ofs_bytes;

    // Scale the offset field to bytes and form both targets.
    always_comb begin
        ofs_bytes = AW'(ofs) << INSTR_SHIFT;
        seq_pc    = pc + AW'(INSTR_BYTES);
        call_pc   = pc + ofs_bytes + AW'(INSTR_BYTES);
    end
endmodule

// File: rtl/ccr_stack.sv
// Hardware stack of (value, return address) pairs.
// push writes a pair on top; pop discards the top pair. The top pair is
// readable combinationally. The caller must never push when full, never
// pop when empty, and never do both in the same cycle.
// The storage itself is not reset; only the depth counter is.
module ccr_stack #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 64,
    parameter int unsigned AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] push_val,
    input  logic [AW-1:0] push_ret,
    output logic [DW-1:0] top_val,
    output logic [AW-1:0] top_ret,
    output logic          empty,
    output logic          full
);
    localparam int unsigned CW   = $clog2(DEPTH + 1);
    localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0]   val_mem [DEPTH];
    logic [AW-1:0]   ret_mem [DEPTH];
    logic [CW-1:0]   count_q;
    logic [IDXW-1:0] wr_idx;
    logic [IDXW-1:0] top_idx;

    // Derive the write slot, the top slot and the status flags from the depth.
    always_comb begin
        wr_idx  = IDXW'(count_q);
        top_idx = IDXW'(count_q - CW'(1));
        empty   = (count_q == '0);
        full    = (count_q == CW'(DEPTH));
        top_val = val_mem[top_idx];
        top_ret = ret_mem[top_idx];
    end

    // Track the depth of the stack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (push) begin
            count_q <= count_q + CW'(1);
        end else if (pop) begin
            count_q <= count_q - CW'(1);
        end
    end

    // Write the pushed pair into the storage.
    always_ff @(posedge clk) begin
        if (push) begin
            val_mem[wr_idx] <= push_val;
            ret_mem[wr_idx] <= push_ret;
        end
    end

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    // R7
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> count_q == $past(count_q) + CW'(1));
    // R7
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> count_q == $past(count_q) - CW'(1));
    // R7
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/ccr_unit.sv
// Conditional call/return control unit (top).
// Each cycle with in_valid high, it evaluates the branch condition,
// updates the call stack and registers the next pc, the C result and the
// C write strobe. The results appear one cycle after the instruction.
// A return on an empty stack, or a call on a full stack, is refused and
// acts as C = A. A call refused for lack of space sets the sticky overflow
// flag.
module ccr_unit #(
    parameter int unsigned DW    = 64,
    parameter int unsigned IW    = 32,
    parameter int unsigned AW    = 32,
    parameter int unsigned OW    = 7,
    parameter int unsigned DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_op,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [OW-1:0] call_ofs,
    input  logic [IW-1:0] imm1,
    input  logic          uncond,
    input  logic [AW-1:0] pc,
    output logic          out_valid,
    output logic          out_taken,
    output logic [AW-1:0] out_next_pc,
    output logic [DW-1:0] out_c,
    output logic          out_c_wr,
    output logic          stack_empty,
    output logic          stack_full,
    output logic          overflow
);
    import ccr_pkg::*;

    logic          cond;
    logic [AW-1:0] seq_pc;
    logic [AW-1:0] call_pc;
    logic [DW-1:0] top_val;
    logic [AW-1:0] top_ret;
    logic          is_call;
    logic          is_ret;
    logic          call_tk;
    logic          ret_tk;
    logic          call_ovf;
    logic          do_push;
    logic          do_pop;
    logic          nx_taken;
    logic [AW-1:0] nx_pc;
    logic [DW-1:0] nx_c;
    logic          nx_cwr;

    logic          valid_q;
    logic          taken_q;
    logic [AW-1:0] npc_q;
    logic [DW-1:0] c_q;
    logic          cwr_q;
    logic          ovf_q;

    ccr_cond #(.DW(DW), .IW(IW)) u_cond (
        .b      (op_b),
        .bound  (imm1),
        .uncond (uncond),
        .cond   (cond)
    );

    ccr_target #(.AW(AW), .OW(OW)) u_target (
        .pc      (pc),
        .ofs     (call_ofs),
        .seq_pc  (seq_pc),
        .call_pc (call_pc)
    );

    ccr_stack #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (op_a),
        .push_ret (seq_pc),
        .top_val  (top_val),
        .top_ret  (top_ret),
        .empty    (stack_empty),
        .full     (stack_full)
    );

    // Decode the operation and settle the branch outcome against stack state.
    always_comb begin
        is_call  = in_valid && (ccr_op_e'(in_op) == OP_CALL);
        is_ret   = in_valid && (ccr_op_e'(in_op) == OP_RET);
        call_tk  = is_call && cond && !stack_full;
        call_ovf = is_call && cond && stack_full;
        ret_tk   = is_ret && cond && !stack_empty;
        do_push  = call_tk;
        do_pop   = ret_tk;
    end

    // Select the next pc, the C result and the write strobe.
    always_comb begin
        nx_taken = call_tk || ret_tk;
        nx_pc    = seq_pc;
        nx_c     = op_a;
        nx_cwr   = 1'b1;
        if (call_tk) begin
            nx_pc  = call_pc;
            nx_cwr = 1'b0;
        end else if (ret_tk) begin
            nx_pc  = top_ret;
            nx_c   = op_a ^ top_val;
        end
    end

    // Register the results of an accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            taken_q <= 1'b0;
            npc_q   <= '0;
            c_q     <= '0;
            cwr_q   <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                taken_q <= nx_taken;
                npc_q   <= nx_pc;
                c_q     <= nx_c;
                cwr_q   <= nx_cwr;
            end else begin
                cwr_q   <= 1'b0;
            end
        end
    end

    // Hold the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (call_ovf) begin
            ovf_q <= 1'b1;
        end
    end

    assign out_valid   = valid_q;
    assign out_taken   = taken_q;
    assign out_next_pc = npc_q;
    assign out_c       = c_q;
    assign out_c_wr    = cwr_q;
    assign overflow    = ovf_q;

    // R5
    ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ret && stack_empty) |=> (out_valid && !out_taken));
    // R8
    no_overflow_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_call && stack_full) |=> (out_valid && !out_taken && out_c_wr));
    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    not_taken_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken) |-> out_c_wr);
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: tb/sim_ccr_unit.sv
module sim_ccr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [6:0]  call_ofs = '0;
    logic [31:0] imm1 = '0;
    logic        uncond = 1'b0;
    logic [31:0] pc = '0;
    logic        out_valid, out_taken, out_c_wr;
    logic [31:0] out_next_pc;
    logic [63:0] out_c;
    logic        stack_empty, stack_full, overflow;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Bench model of the stack, built from the requirements.
    logic [63:0] m_val [16];
    logic [31:0] m_ret [16];
    int          m_cnt = 0;
    bit          m_ovf = 1'b0;

    ccr_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .op_a(op_a), .op_b(op_b), .call_ofs(call_ofs), .imm1(imm1),
        .uncond(uncond), .pc(pc), .out_valid(out_valid), .out_taken(out_taken),
        .out_next_pc(out_next_pc), .out_c(out_c), .out_c_wr(out_c_wr),
        .stack_empty(stack_empty), .stack_full(stack_full), .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One instruction: drive, deassert, then check the registered result.
    task automatic instr(input string req, input bit op, input logic [63:0] a,
                         input logic [63:0] b, input logic [6:0] ofs,
                         input logic [31:0] im, input bit unc, input logic [31:0] p);
        bit          cond, tk;
        logic [31:0] enpc;
        logic [63:0] ec;
        bit          ewr;
        cond = unc || (b <= {32'h0, im});
        enpc = p + 32'd16;
        ec   = a;
        ewr  = 1'b1;
        tk   = 1'b0;
        if (op == 1'b0) begin
            if (cond && m_cnt < 16) begin
                tk = 1'b1;
                enpc = p + ({25'h0, ofs} + 32'd1) * 32'd16;
                ewr = 1'b0;
                m_val[m_cnt] = a;
                m_ret[m_cnt] = p + 32'd16;
                m_cnt++;
            end else if (cond) begin
                m_ovf = 1'b1;
            end
        end else if (cond && m_cnt > 0) begin
            tk = 1'b1;
            m_cnt--;
            enpc = m_ret[m_cnt];
            ec = a ^ m_val[m_cnt];
        end
        @(negedge clk);
        in_valid = 1'b1; in_op = op; op_a = a; op_b = b; call_ofs = ofs;
        imm1 = im; uncond = unc; pc = p;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "out_valid", {63'h0, out_valid}, 64'h1);
        chk(req, "taken", {63'h0, out_taken}, {63'h0, tk});
        chk(req, "next_pc", {32'h0, out_next_pc}, {32'h0, enpc});
        chk(req, "c_wr", {63'h0, out_c_wr}, {63'h0, ewr});
        if (ewr) chk(req, "c", out_c, ec);
        chk(req, "empty", {63'h0, stack_empty}, {63'h0, m_cnt == 0});
        chk(req, "full", {63'h0, stack_full}, {63'h0, m_cnt == 16});
        chk(req, "overflow", {63'h0, overflow}, {63'h0, m_ovf});
    endtask

    task automatic t_reset();
        chk("R1", "out_valid", {63'h0, out_valid}, 64'h0);
        chk("R1", "empty", {63'h0, stack_empty}, 64'h1);
        chk("R1", "full", {63'h0, stack_full}, 64'h0);
        chk("R1", "overflow", {63'h0, overflow}, 64'h0);
    endtask

    task automatic t_ret_empty();
        // R5: an unconditional return on an empty stack is refused.
        instr("R5", 1'b1, 64'h1234_5678_9abc_def0, 64'h0, 7'd0, 32'h0, 1'b1, 32'h100);
        instr("R5", 1'b1, 64'h55, 64'h0, 7'd3, 32'hffff_ffff, 1'b0, 32'h200);
    endtask

    task automatic t_cond();
        // R2: bound equal to B is taken; one above is not; upper bits count.
        instr("R2", 1'b0, 64'hA1, 64'h0000_0000_0000_1000, 7'd0, 32'h1000, 1'b0, 32'h400);
        instr("R3", 1'b0, 64'hA2, 64'h0000_0000_0000_1001, 7'd0, 32'h1000, 1'b0, 32'h500);
        instr("R2", 1'b0, 64'hA3, 64'h8000_0000_0000_0000, 7'd0, 32'hffff_ffff, 1'b0, 32'h600);
        instr("R2", 1'b0, 64'hA4, 64'h0000_0001_0000_0000, 7'd0, 32'hffff_ffff, 1'b0, 32'h640);
        instr("R2", 1'b0, 64'hA5, 64'hffff_ffff_ffff_ffff, 7'd1, 32'h0, 1'b1, 32'h700);
        // R3: a return whose condition fails is a copy.
        instr("R3", 1'b1, 64'hB0, 64'h10, 7'd0, 32'h0f, 1'b0, 32'h800);
        instr("R6", 1'b1, 64'hF0, 64'h0, 7'd0, 32'h0, 1'b1, 32'h900);
        instr("R6", 1'b1, 64'hF1, 64'h5, 7'd0, 32'h5, 1'b0, 32'h980);
    endtask

    task automatic t_offsets();
        // R4: smallest and largest call distances.
        instr("R4", 1'b0, 64'hC0, 64'h0, 7'd0, 32'h0, 1'b1, 32'h1000);
        instr("R4", 1'b0, 64'hC1, 64'h0, 7'd127, 32'h0, 1'b1, 32'h2000);
        instr("R6", 1'b1, 64'h0F, 64'h0, 7'd0, 32'h0, 1'b1, 32'h3000);
        instr("R6", 1'b1, 64'hF0, 64'h0, 7'd0, 32'h0, 1'b1, 32'h3010);
    endtask

    task automatic t_idle();
        // R9: idle cycles with live-looking inputs leave the stack alone.
        instr("R4", 1'b0, 64'hDEAD, 64'h0, 7'd2, 32'h0, 1'b1, 32'h4000);
        @(negedge clk);
        in_op = 1'b1; uncond = 1'b1; op_a = 64'h77;
        repeat (3) @(negedge clk);
        chk("R9", "out_valid", {63'h0, out_valid}, 64'h0);
        chk("R9", "empty", {63'h0, stack_empty}, 64'h0);
        instr("R9", 1'b1, 64'hBEEF, 64'h0, 7'd0, 32'h0, 1'b1, 32'h4100);
    endtask

    task automatic t_nest();
        // R7: three nested calls unwind in reverse order.
        for (int i = 0; i < 3; i++)
            instr("R7", 1'b0, 64'h1111 * (i + 1), 64'h0, 7'(i), 32'h0, 1'b1, 32'h5000 + 32'(i) * 32'h100);
        for (int i = 0; i < 3; i++)
            instr("R7", 1'b1, 64'hFF00 + 64'(i), 64'h3, 7'd0, 32'h3, 1'b0, 32'h6000 + 32'(i) * 32'h10);
    endtask

    task automatic t_overflow();
        // R8: fill the stack, then a call is refused and sets overflow.
        for (int i = 0; i < 16; i++)
            instr("R8", 1'b0, 64'hE000 + 64'(i), 64'h0, 7'd0, 32'h0, 1'b1, 32'h8000 + 32'(i) * 32'h40);
        instr("R8", 1'b0, 64'hEEEE, 64'h0, 7'd5, 32'h0, 1'b1, 32'h9000);
        // R10: draining the stack keeps overflow set.
        for (int i = 0; i < 16; i++)
            instr("R10", 1'b1, 64'h0, 64'h0, 7'd0, 32'h0, 1'b1, 32'hA000);
        instr("R10", 1'b1, 64'h9, 64'h0, 7'd0, 32'h0, 1'b1, 32'hB000);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ret_empty();
        t_cond();
        t_offsets();
        t_idle();
        t_nest();
        t_overflow();
        done = 1'b1;
        finish_run();
    end
endmodule